// File: doc/BRIEF.md
# Two-Address Breakpoint Comparator

This block watches one CPU bus and reports when an access matches a breakpoint built from two programmable addresses, A and B. Each address has its own access filter, which accepts instruction fetches, data reads, data writes, or data reads and writes together. A filter can also be switched off. The two addresses are combined under one of five modes:
- A alone.
- B alone.
- Either A or B.
- An inclusive address window from A up to B.
- An ordered pair, in which a qualified access to A must come before a later qualified access to B.

Software programs the block through a small write port. That port holds the two addresses, a control word with the mode, both filters and a master enable, and a write-one-to-clear for the status bit. The block has two outputs. One is a one-cycle hit pulse, registered from the sampled bus. The other is a sticky hit bit, which stays set until software clears it. A higher layer turns the hit into a CPU halt.

Top module: `bkpt_pair_unit`

## Requirements
- R1: While reset is held, and after it is released, hit and sticky are 0. Both addresses and the control word are 0, the enable is off, and the ordered-pair tracker is idle.
- R2: A write selects its register by cfg_sel: 0 is address A, 1 is address B, 2 is the control word and 3 is the status clear. The control word puts the mode in bits [2:0], the filter of A in [5:3], the filter of B in [8:6] and the enable in bit 9.
- R3: bus_kind codes are 0 for fetch, 1 for read and 2 for write; code 3 matches nothing. Filter codes are 1 for fetch only, 2 for read only, 3 for write only and 4 for read or write. Codes 0, 5, 6 and 7 never match.
- R4: Mode 0 hits on a valid access whose address equals A and whose kind passes the filter of A. Mode 1 does the same with B and the filter of B.
- R5: Mode 2 hits when either the A condition or the B condition of R4 holds.
- R6: Mode 3 hits when A <= address <= B and the kind passes the filter of A. Both ends are inclusive. The filter of B is not used, and there is no hit when A > B.
- R7: In mode 4, a qualified access to A arms the tracker. A later qualified access to B while armed produces a hit and disarms. An access to B while not armed gives no hit.
- R8: In mode 4, when the tracker is idle, an access that qualifies for both A and B only arms; it does not hit.
- R9: Any configuration write disarms the ordered-pair tracker.
- R10: hit is registered. It is high for the one cycle after the clock edge that samples a matching access, and it stays low when bus_valid is low.
- R11: sticky is set together with hit. Writing 1 to bit 0 of register 3 clears it. If a hit and a clear occur in the same cycle, the set wins.
- R12: With the enable off, or with mode codes 5 to 7, no access ever hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| bus_addr | input | ADDR_W | Access address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | max(ADDR_W,10) | Write data |
| hit | output | 1 | One-cycle match pulse |
| sticky | output | 1 | Hit status held until cleared |

## Verification
The hardest case to reach is the ordered-pair tracker being in the wrong state when B arrives. This covers three situations:
- B arrives after a configuration write has disarmed the tracker.
- A and B are equal, so one access qualifies for both.
- A lingering armed state leaks across filter settings.

The bench runs every mode against every filter pair over the whole address space of a 6-bit build. Its own model carries the armed flag forward through the sweep, so many arm and fire orderings occur. Directed sequences then place a configuration write between A and B, set A equal to B, and issue a status clear in the same cycle as a hit.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   localparam int CTRL_W = 10;

   // mode codes
   localparam logic [2:0] MODE_A      = 3'd0;
   localparam logic [2:0] MODE_B      = 3'd1;
   localparam logic [2:0] MODE_EITHER = 3'd2;
   localparam logic [2:0] MODE_AREA   = 3'd3;
   localparam logic [2:0] MODE_SEQ    = 3'd4;

   // access filter codes
   localparam logic [2:0] QF_OFF  = 3'd0;
   localparam logic [2:0] QF_EXEC = 3'd1;
   localparam logic [2:0] QF_RD   = 3'd2;
   localparam logic [2:0] QF_WR   = 3'd3;
   localparam logic [2:0] QF_RDWR = 3'd4;

   // bus access kinds
   localparam logic [1:0] KIND_FETCH = 2'd0;
   localparam logic [1:0] KIND_READ  = 2'd1;
   localparam logic [1:0] KIND_WRITE = 2'd2;

   // register selects
   localparam logic [1:0] SEL_ADDR_A = 2'd0;
   localparam logic [1:0] SEL_ADDR_B = 2'd1;
   localparam logic [1:0] SEL_CTRL   = 2'd2;
   localparam logic [1:0] SEL_STAT   = 2'd3;
endpackage

// File: rtl/bkpt_qual.sv
module bkpt_qual
   import bkpt_pkg::*;
(
   input  logic [2:0] filt,
   input  logic [1:0] kind,
   output logic       pass
);
   always_comb begin
      case (filt)
         QF_EXEC: pass = (kind == KIND_FETCH);
         QF_RD:   pass = (kind == KIND_READ);
         QF_WR:   pass = (kind == KIND_WRITE);
         QF_RDWR: pass = (kind == KIND_READ) || (kind == KIND_WRITE);
         default: pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
   parameter int W = 16
) (
   input  logic [W-1:0] addr,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic         eq_lo,
   output logic         eq_hi,
   output logic         in_win
);
   always_comb begin
      eq_lo  = (addr == lo);
      eq_hi  = (addr == hi);
      in_win = (addr >= lo) && (addr <= hi);
   end
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq (
   input  logic clk,
   input  logic rst,
   input  logic flush,
   input  logic active,
   input  logic first_ok,
   input  logic second_ok,
   output logic armed,
   output logic fire
);
   assign fire = active && armed && second_ok;

   always_ff @(posedge clk) begin
      if (rst || flush || !active) begin
         armed <= 1'b0;
      end else if (fire) begin
         armed <= 1'b0;
      end else if (first_ok) begin
         armed <= 1'b1;
      end
   end
endmodule

// File: rtl/bkpt_pair_unit.sv
module bkpt_pair_unit
   import bkpt_pkg::*;
#(
   parameter int ADDR_W = 16,
   localparam int WD_W = (ADDR_W > CTRL_W) ? ADDR_W : CTRL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_valid,
   input  logic [1:0]        bus_kind,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [WD_W-1:0]   cfg_wdata,
   output logic              hit,
   output logic              sticky
);
   if (ADDR_W < 2) begin : g_bad_width
      $error("bkpt_pair_unit: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] reg_a, reg_b;
   logic [2:0]        ctl_mode;
   logic [2:0]        ctl_filt [2];
   logic              ctl_en;
   logic [1:0]        filt_ok;
   logic              eq_a, eq_b, in_win;
   logic              hit_a, hit_b, seq_fire, seq_armed, seq_active;
   logic              match, clr_req;

   // configuration registers
   always_ff @(posedge clk) begin
      if (rst) begin
         reg_a       <= '0;
         reg_b       <= '0;
         ctl_mode    <= MODE_A;
         ctl_filt[0] <= QF_OFF;
         ctl_filt[1] <= QF_OFF;
         ctl_en      <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_ADDR_A: reg_a <= cfg_wdata[ADDR_W-1:0];
            SEL_ADDR_B: reg_b <= cfg_wdata[ADDR_W-1:0];
            SEL_CTRL: begin
               ctl_mode    <= cfg_wdata[2:0];
               ctl_filt[0] <= cfg_wdata[5:3];
               ctl_filt[1] <= cfg_wdata[8:6];
               ctl_en      <= cfg_wdata[9];
            end
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < 2; i++) begin : g_filt
      bkpt_qual u_qual (
         .filt (ctl_filt[i]),
         .kind (bus_kind),
         .pass (filt_ok[i])
      );
   end

   bkpt_cmp #(.W(ADDR_W)) u_cmp (
      .addr   (bus_addr),
      .lo     (reg_a),
      .hi     (reg_b),
      .eq_lo  (eq_a),
      .eq_hi  (eq_b),
      .in_win (in_win)
   );

   assign hit_a      = bus_valid && eq_a && filt_ok[0];
   assign hit_b      = bus_valid && eq_b && filt_ok[1];
   assign seq_active = ctl_en && (ctl_mode == MODE_SEQ);

   bkpt_seq u_seq (
      .clk       (clk),
      .rst       (rst),
      .flush     (cfg_we),
      .active    (seq_active),
      .first_ok  (hit_a),
      .second_ok (hit_b),
      .armed     (seq_armed),
      .fire      (seq_fire)
   );

   always_comb begin
      match = 1'b0;
      if (ctl_en) begin
         case (ctl_mode)
            MODE_A:      match = hit_a;
            MODE_B:      match = hit_b;
            MODE_EITHER: match = hit_a || hit_b;
            MODE_AREA:   match = bus_valid && in_win && filt_ok[0];
            MODE_SEQ:    match = seq_fire;
            default:     match = 1'b0;
         endcase
      end
   end

   assign clr_req = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         hit    <= 1'b0;
         sticky <= 1'b0;
      end else begin
         hit <= match;
         if (match) begin
            sticky <= 1'b1;
         end else if (clr_req) begin
            sticky <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bkpt_pair_chk.sv
module bkpt_pair_chk
   import bkpt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WD_W   = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              cfg_we,
   input logic [1:0]        cfg_sel,
   input logic [WD_W-1:0]   cfg_wdata,
   input logic              hit,
   input logic              sticky,
   input logic [ADDR_W-1:0] reg_a,
   input logic [ADDR_W-1:0] reg_b,
   input logic [2:0]        ctl_mode,
   input logic              ctl_en,
   input logic              seq_armed
);
   // R10
   valid_src_chk: assert property (@(posedge clk) disable iff (rst)
      hit |-> $past(bus_valid));

   // R11
   sticky_follow_chk: assert property (@(posedge clk) disable iff (rst)
      hit |-> sticky);

   // R11
   sticky_drop_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(sticky) |-> $past(cfg_we && cfg_sel == SEL_STAT && cfg_wdata[0]));

   // R6
   area_bounds_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && $past(ctl_mode == MODE_AREA))
         |-> $past(bus_addr >= reg_a && bus_addr <= reg_b));

   // R7
   seq_armed_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && $past(ctl_mode == MODE_SEQ)) |-> $past(seq_armed));

   // R9
   flush_disarm_chk: assert property (@(posedge clk) disable iff (rst)
      $past(cfg_we) |-> !seq_armed);

   // R12
   enable_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!ctl_en) |-> !hit);
endmodule

bind bkpt_pair_unit bkpt_pair_chk #(.ADDR_W(ADDR_W), .WD_W(WD_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_valid (bus_valid),
   .bus_addr  (bus_addr),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .hit       (hit),
   .sticky    (sticky),
   .reg_a     (reg_a),
   .reg_b     (reg_b),
   .ctl_mode  (ctl_mode),
   .ctl_en    (ctl_en),
   .seq_armed (seq_armed)
);

// File: tb/bkpt_pair_unit_test.sv
module bkpt_pair_unit_test;
   localparam int AW  = 6;
   localparam int WDW = 10;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           bus_valid = 1'b0;
   logic [1:0]     bus_kind = 2'd0;
   logic [AW-1:0]  bus_addr = '0;
   logic           cfg_we = 1'b0;
   logic [1:0]     cfg_sel = 2'd0;
   logic [WDW-1:0] cfg_wdata = '0;
   logic           hit, sticky;

   int n_chk = 0;
   int n_bad = 0;

   // bench model of the programmed state
   int  m_a = 0, m_b = 0, m_mode = 0, m_qa = 0, m_qb = 0;
   bit  m_en = 0;
   bit  m_armed = 0;

   always #4 clk = ~clk;

   bkpt_pair_unit #(.ADDR_W(AW)) uut (
      .clk       (clk),
      .rst       (rst),
      .bus_valid (bus_valid),
      .bus_kind  (bus_kind),
      .bus_addr  (bus_addr),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .hit       (hit),
      .sticky    (sticky)
   );

   function automatic bit kind_ok(int q, int k);
      case (q)
         1: return k == 0;
         2: return k == 1;
         3: return k == 2;
         4: return (k == 1) || (k == 2);
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(bit act, bit exp, string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic cfg_write(int sel, int data);
      cfg_we    = 1'b1;
      cfg_sel   = 2'(sel);
      cfg_wdata = WDW'(data);
      bus_valid = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
      m_armed = 0;
      case (sel)
         0: m_a = data % (1 << AW);
         1: m_b = data % (1 << AW);
         2: begin
            m_mode = data & 7;
            m_qa   = (data >> 3) & 7;
            m_qb   = (data >> 6) & 7;
            m_en   = ((data >> 9) & 1) != 0;
         end
         default: ;
      endcase
   endtask

   task automatic set_ctrl(int mode, int qa, int qb, int en);
      cfg_write(2, (en << 9) | (qb << 6) | (qa << 3) | mode);
   endtask

   function automatic bit model_exp(int addr, int k, bit v);
      bit ha, hb, inw, r;
      ha  = v && addr == m_a && kind_ok(m_qa, k);
      hb  = v && addr == m_b && kind_ok(m_qb, k);
      inw = v && addr >= m_a && addr <= m_b && kind_ok(m_qa, k);
      case (m_mode)
         0: r = ha;
         1: r = hb;
         2: r = ha || hb;
         3: r = inw;
         4: r = m_armed && hb;
         default: r = 1'b0;
      endcase
      return m_en && r;
   endfunction

   function automatic void model_adv(int addr, int k, bit v);
      bit ha, hb;
      ha = v && addr == m_a && kind_ok(m_qa, k);
      hb = v && addr == m_b && kind_ok(m_qb, k);
      if (!(m_en && m_mode == 4)) m_armed = 0;
      else if (m_armed && hb)     m_armed = 0;
      else if (ha)                m_armed = 1;
   endfunction

   task automatic step(int addr, int k, bit v, string tag);
      bit e;
      e = model_exp(addr, k, v);
      model_adv(addr, k, v);
      bus_valid = v;
      bus_kind  = 2'(k);
      bus_addr  = AW'(addr);
      @(negedge clk);
      check(hit, e, tag);
   endtask

   function automatic string mode_tag(int m);
      case (m)
         0, 1: return "R4 filter R3";
         2:    return "R5 filter R3";
         3:    return "R6 filter R3";
         4:    return "R7 filter R3";
         default: return "R12";
      endcase
   endfunction

   initial begin
      #(8 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(hit, 1'b0, "R1 hit in reset");
      check(sticky, 1'b0, "R1 sticky in reset");
      rst = 1'b0;
      @(negedge clk);
      check(hit, 1'b0, "R1 hit after reset");
      check(sticky, 1'b0, "R1 sticky after reset");
      step(0, 0, 1'b1, "R1 no hit from reset config");

      // R2 register mapping
      cfg_write(0, 5);
      cfg_write(1, 9);
      set_ctrl(0, 1, 2, 1);
      step(5, 0, 1'b1, "R2 address A via select 0");
      set_ctrl(1, 1, 2, 1);
      step(9, 1, 1'b1, "R2 address B via select 1");

      // R10 valid low and pulse width
      step(9, 1, 1'b0, "R10 valid low");
      step(9, 1, 1'b1, "R10 pulse");
      step(3, 1, 1'b1, "R10 pulse ends");

      // exhaustive sweep over modes, filters, addresses and kinds
      for (int m = 0; m < 5; m++) begin
         for (int qa = 0; qa < 5; qa++) begin
            for (int qb = 0; qb < 5; qb++) begin
               set_ctrl(m, qa, qb, 1);
               for (int ad = 0; ad < (1 << AW); ad++) begin
                  for (int k = 0; k < 4; k++) begin
                     step(ad, k, 1'b1, mode_tag(m));
                  end
               end
            end
         end
      end

      // R6 window edges: A equal to B, and A above B
      cfg_write(0, 20);
      cfg_write(1, 20);
      set_ctrl(3, 4, 0, 1);
      for (int ad = 18; ad < 23; ad++) step(ad, 2, 1'b1, "R6 single-address window");
      cfg_write(0, 40);
      cfg_write(1, 30);
      for (int ad = 0; ad < (1 << AW); ad++) step(ad, 1, 1'b1, "R6 inverted window");

      // R8 A equal to B in ordered mode
      cfg_write(0, 7);
      cfg_write(1, 7);
      set_ctrl(4, 1, 1, 1);
      step(7, 0, 1'b1, "R8 first arms only");
      step(7, 0, 1'b1, "R8 second fires");
      step(7, 0, 1'b1, "R8 third re-arms only");

      // R9 configuration write disarms
      cfg_write(0, 5);
      cfg_write(1, 9);
      set_ctrl(4, 1, 1, 1);
      step(5, 0, 1'b1, "R9 arm");
      cfg_write(0, 5);
      step(9, 0, 1'b1, "R9 B after write");
      step(5, 0, 1'b1, "R9 re-arm");
      step(9, 0, 1'b1, "R7 B after arm");
      step(9, 0, 1'b1, "R7 B when idle");

      // R12 enable off and undefined modes
      set_ctrl(2, 4, 4, 0);
      step(5, 1, 1'b1, "R12 enable off");
      for (int m = 5; m < 8; m++) begin
         set_ctrl(m, 4, 4, 1);
         step(5, 1, 1'b1, "R12 undefined mode");
         step(9, 2, 1'b1, "R12 undefined mode");
      end

      // R11 sticky behaviour
      cfg_write(3, 1);
      check(sticky, 1'b0, "R11 cleared");
      set_ctrl(0, 1, 0, 1);
      step(5, 0, 1'b1, "R11 hit sets");
      check(sticky, 1'b1, "R11 sticky set");
      step(6, 0, 1'b1, "R11 no hit");
      check(sticky, 1'b1, "R11 sticky held");
      cfg_write(3, 0);
      check(sticky, 1'b1, "R11 write zero keeps");
      cfg_we    = 1'b1;
      cfg_sel   = 2'd3;
      cfg_wdata = WDW'(1);
      bus_valid = 1'b1;
      bus_kind  = 2'd0;
      bus_addr  = AW'(5);
      @(negedge clk);
      cfg_we = 1'b0;
      bus_valid = 1'b0;
      check(hit, 1'b1, "R11 hit during clear");
      check(sticky, 1'b1, "R11 set wins over clear");
      cfg_write(3, 1);
      check(sticky, 1'b0, "R11 clear alone");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule